// File: doc/BRIEF.md
# Circular-History Echo Mixer

This block is a streaming audio effect for signed 24-bit samples. It keeps the most recent 4096 accepted samples in an on-chip memory that one address pointer walks around. Each accepted sample first reads the slot under the pointer, which holds the sample accepted 4096 samples before. The new sample is then written into that slot and the pointer steps on, wrapping from the last slot back to zero. The output is a weighted mix of the new sample (the dry path) and the sample read from the slot (the delayed path). At 48 kHz the 4096-sample history gives a delay of about 85 ms, which is enough for a crude echo or reverb.

The mix weight `a` is an unsigned 8-bit fraction (value/256). It applies to the dry sample, and the delayed sample gets `256 - a`, so the two weights always add up to exactly one. The weight is taken from the same cycle as its sample, so it can be changed at run time. After reset, history that has not been filled yet counts as silence. The first pass of the pointer therefore never replays old memory contents.

Top module: `echo_ring_fx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_sample` is 0.
- R2: Every cycle with `in_valid` = 1 produces exactly one cycle of `out_valid` = 1, two clock edges later. `out_valid` is never 1 at any other time.
- R3: The output value is floor((x·a + d·(256−a) + 128) / 256). Here x is the input sample, a is `in_coef` read as an unsigned integer 0..255 and taken in the same cycle as x, and d is the delayed sample. The division rounds to nearest, with halves going upward.
- R4: d is the input accepted exactly 4096 accepted samples earlier. Cycles with `in_valid` = 0 do not advance the history.
- R5: For the first 4096 samples accepted after reset, d is 0, whatever the memory held before.
- R6: With a = 0 the output equals d exactly. With a = 255 the output is x·255/256 + d/256, rounded as in R3.
- R7: The output lies in the signed 24-bit range −8388608..8388607 and saturates to the nearer limit if the mix ever exceeds it. Full-scale inputs mixed at a = 128 give 8388607 for max with max, −8388608 for min with min, and 0 for max with min.
- R8: A reset in the middle of a stream discards the stored history. After reset, samples again see d = 0 as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe, one cycle per audio frame |
| in_sample | input | 24 | Incoming sample, two's complement |
| in_coef | input | 8 | Dry weight a, unsigned fraction of 256 |
| out_valid | output | 1 | Mixed sample strobe, two edges after `in_valid` |
| out_sample | output | 24 | Mixed sample, two's complement |

## Verification
Two events fall on the same cycle: the last slot of the first pass is read while still being treated as silence, and the pointer wraps and sets the history-filled state. The very next sample is the first one to read real history. This corner is provoked by sending exactly 4096 samples after reset, with idle gaps in between, and then a burst at a = 0. It is judged by checking that sample 4095 still mixes with zero and that sample 4096 returns sample 0 exactly. A second coincidence is the read of a slot and the write of the new sample into that same slot on the same edge. Back-to-back bursts show that the value read is always the older one.

// File: rtl/echo_pkg.sv
// Package: shared sizes for the circular-history echo mixer.
// Assumes two's-complement samples and an unsigned fractional weight.
package echo_pkg;
    parameter int SAMPLE_W = 24;   // audio sample width
    parameter int COEF_W   = 8;    // dry-weight width, fraction of 2**COEF_W
    parameter int HIST_AW  = 12;   // history address width (4096 slots)
endpackage

// File: rtl/echo_ptr.sv
// Module: echo_ptr
// Walks one address around the history memory, one step per accepted
// sample, and records whether a full pass has completed since reset.
// Assumes the memory depth is exactly 2**AW, so wrap is natural overflow.
module echo_ptr #(
    parameter int AW = echo_pkg::HIST_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          filled
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    // Advance the pointer on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
    end

    // Latch that every slot has been written once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            filled <= 1'b0;
        else if (step && addr == LAST)
            filled <= 1'b1;
    end
endmodule

// File: rtl/echo_ram.sv
// Module: echo_ram
// Single-port synchronous memory with read-before-write: on an enabled
// edge it returns the slot's previous contents and stores the new value.
// Assumes no reset of the array; stale contents are masked upstream.
module echo_ram #(
    parameter int DW = echo_pkg::SAMPLE_W,
    parameter int AW = echo_pkg::HIST_AW
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read the old slot and overwrite it on the same edge.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/echo_mix.sv
// Module: echo_mix
// Combinational blend: dry*a + old*(2**CW - a), rounded to nearest and
// clamped to the signed sample range. A stale flag replaces old by zero.
// Assumes the weight is unsigned and strictly below 2**CW.
module echo_mix #(
    parameter int DW = echo_pkg::SAMPLE_W,
    parameter int CW = echo_pkg::COEF_W
) (
    input  logic signed [DW-1:0] dry,
    input  logic signed [DW-1:0] old,
    input  logic                 old_stale,
    input  logic        [CW-1:0] coef,
    output logic signed [DW-1:0] mixed
);
    localparam int ACC_W = DW + CW + 3;
    localparam logic signed [ACC_W-1:0] ONE_W   = ACC_W'(1) <<< CW;
    localparam logic signed [ACC_W-1:0] HALF_W  = ACC_W'(1) <<< (CW - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI  = (ACC_W'(1) <<< (DW - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO  = -SAT_HI - ACC_W'(1);

    logic signed [ACC_W-1:0] dry_x, old_x, w_dry, w_old, acc, scaled;

    // Widen operands and form both weights.
    always_comb begin
        dry_x = {{(ACC_W-DW){dry[DW-1]}}, dry};
        old_x = old_stale ? '0 : {{(ACC_W-DW){old[DW-1]}}, old};
        w_dry = {{(ACC_W-CW){1'b0}}, coef};
        w_old = ONE_W - w_dry;
    end

    // Weighted sum with round-half-up, then scale back.
    always_comb begin
        acc    = dry_x * w_dry + old_x * w_old + HALF_W;
        scaled = acc >>> CW;
    end

    // Clamp to the sample range.
    always_comb begin
        if (scaled > SAT_HI)
            mixed = SAT_HI[DW-1:0];
        else if (scaled < SAT_LO)
            mixed = SAT_LO[DW-1:0];
        else
            mixed = scaled[DW-1:0];
    end
endmodule

// File: rtl/echo_ring_fx.sv
// Module: echo_ring_fx (top)
// Streaming echo: each accepted sample reads the slot written 2**AW
// samples earlier, overwrites it, and is blended with the old value.
// Stage 1: memory access and input capture. Stage 2: blend and register.
// Assumes at most one sample per cycle; idle cycles leave history intact.
module echo_ring_fx #(
    parameter int DW = echo_pkg::SAMPLE_W,
    parameter int CW = echo_pkg::COEF_W,
    parameter int AW = echo_pkg::HIST_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic        [CW-1:0] in_coef,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);
    logic [AW-1:0]        wr_addr;
    logic                 hist_filled;
    logic [DW-1:0]        rd_word;
    logic                 s1_valid;
    logic signed [DW-1:0] s1_dry;
    logic [CW-1:0]        s1_coef;
    logic                 s1_stale;
    logic signed [DW-1:0] mix_val;

    echo_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (in_valid),
        .addr   (wr_addr),
        .filled (hist_filled)
    );

    echo_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .en    (in_valid && rst_n),
        .addr  (wr_addr),
        .wdata (in_sample),
        .rdata (rd_word)
    );

    // Stage 1: capture the sample, weight and staleness beside the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dry   <= '0;
            s1_coef  <= '0;
            s1_stale <= 1'b1;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_dry   <= in_sample;
                s1_coef  <= in_coef;
                s1_stale <= !hist_filled;
            end
        end
    end

    echo_mix #(.DW(DW), .CW(CW)) u_mix (
        .dry       (s1_dry),
        .old       (rd_word),
        .old_stale (s1_stale),
        .coef      (s1_coef),
        .mixed     (mix_val)
    );

    // Stage 2: register the blended output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_sample <= mix_val;
        end
    end
endmodule

// File: rtl/echo_ring_fx_chk.sv
// Module: echo_ring_fx_chk
// Temporal checks on the echo mixer, bound into every instance.
// Assumes the stimulus holds in_valid low while reset is asserted.
module echo_ring_fx_chk #(
    parameter int DW = echo_pkg::SAMPLE_W,
    parameter int CW = echo_pkg::COEF_W,
    parameter int AW = echo_pkg::HIST_AW
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic        [CW-1:0] in_coef,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_sample,
    input logic [AW-1:0]        wr_addr,
    input logic                 hist_filled
);
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);                                      // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n, 2)) |-> $past(in_valid, 2));           // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0));                     // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_addr == $past(wr_addr) + AW'($past(in_valid))));  // R4

    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n, 2) && $past(in_coef, 2) == '0
         && !$past(hist_filled, 2)) |-> out_sample == '0);                // R5
endmodule

bind echo_ring_fx echo_ring_fx_chk #(.DW(DW), .CW(CW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_coef     (in_coef),
    .out_valid   (out_valid),
    .out_sample  (out_sample),
    .wr_addr     (wr_addr),
    .hist_filled (hist_filled)
);

// File: tb/echo_ring_fx_bench.sv
`timescale 1ns/1ps
module echo_ring_fx_bench;
    localparam int DW    = 24;
    localparam int CW    = 8;
    localparam int DEPTH = 4096;
    localparam int WD    = 150000;
    localparam longint SMAX = 64'sd8388607;
    localparam longint SMIN = -64'sd8388608;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic        [CW-1:0] in_coef = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_sample;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    longint hist [DEPTH];
    int acc_cnt = 0;

    echo_ring_fx u_echo_ring_fx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_coef(in_coef), .out_valid(out_valid), .out_sample(out_sample)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        wait (cyc >= WD);
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected < %0d", cyc, WD);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Stimulus value for sample index i (full-scale values at chosen indices).
    function automatic logic signed [DW-1:0] gen(input int i);
        logic [31:0] h;
        case (i)
            100, 102, 4197, 4198: return DW'(SMAX);
            101, 103, 4196, 4199: return DW'(SMIN);
            default: begin
                h = (32'(i) * 32'd2654435761) ^ 32'h5a3c_96e1;
                return h[DW-1:0];
            end
        endcase
    endfunction

    // Reference model from R3..R7: consume one sample, return expected output.
    function automatic longint model(input longint x, input int a);
        longint d, acc, r;
        int slot = acc_cnt % DEPTH;
        d = (acc_cnt >= DEPTH) ? hist[slot] : 0;
        hist[slot] = x;
        acc_cnt++;
        acc = x * a + d * (256 - a) + 128;
        r = acc >>> 8;
        if (r > SMAX) r = SMAX;
        if (r < SMIN) r = SMIN;
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        acc_cnt = 0;
        @(negedge clk);
    endtask

    // R1: quiet outputs right after reset.
    task automatic t_reset_state();
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(out_sample == '0, "R1 out_sample after reset", out_sample, 0);
    endtask

    // One isolated sample: checks R2 timing and the R3 value.
    task automatic t_single(input int idx, input int a, input string req);
        longint e;
        logic signed [DW-1:0] x = gen(idx);
        e = model(x, a);
        in_sample = x; in_coef = CW'(a); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R2 not after one edge", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid after two edges", out_valid, 1);
        check(out_sample == DW'(e), req, out_sample, e);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 single pulse", out_valid, 0);
    endtask

    // Back-to-back burst of n samples starting at index first.
    task automatic t_burst(input int first, input int n, input int a, input string req);
        longint ex [] = new[n];
        for (int i = 0; i < n + 2; i++) begin
            if (i >= 2) begin
                check(out_valid == 1'b1, "R2 burst valid", out_valid, 1);
                check(out_sample == DW'(ex[i-2]), req, out_sample, ex[i-2]);
            end
            if (i < n) begin
                in_sample = gen(first + i);
                in_coef = CW'(a);
                in_valid = 1'b1;
                ex[i] = model(gen(first + i), a);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R2 burst end", out_valid, 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        // R5: empty history mixes with silence.
        for (int i = 0; i < 10; i++) t_single(i, 128, "R5 empty history half mix");
        // Fill with idle gaps between bursts (R4: idle does not advance).
        t_burst(10, 2038, 77, "R3 mix a=77");
        for (int i = 2048; i < 2053; i++) t_single(i, 13, "R4 gap fill a=13");
        t_burst(2053, 2042, 255, "R5 fill before wrap");
        t_single(4095, 0, "R5 last empty slot reads zero");
        // Wrap boundary: first sample with real history, pure delay (R4, R6).
        t_burst(4096, 100, 0, "R6 a=0 returns delayed sample R4");
        // Full-scale extremes at half mix (R7).
        t_burst(4196, 4, 128, "R7 extreme half mix");
        t_burst(4200, 100, 255, "R6 a=255 dry dominated");
        for (int i = 4300; i < 4305; i++) t_single(i, 1, "R3 mix a=1");
        // Mid-stream reset discards history (R8).
        do_reset();
        t_reset_state();
        t_single(0, 0, "R8 history cleared a=0");
        t_burst(1, 20, 0, "R8 history cleared burst");
        t_burst(21, 20, 200, "R8 dry only after reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule